// File: doc/BRIEF.md
# Programmable CIC Decimation Filter

This block is a cascaded integrator-comb decimator. It takes one 16-bit two's-complement sample on every rising clock edge once it has been started, and it delivers one filtered 16-bit sample for every N accepted inputs. Up to five integrators run at the input rate. A counter produces a decimation strobe that moves the last integrator's value into a decimation register. Up to five combs then difference successive decimated values. A rounder turns the result into 16 bits, rounding symmetrically and saturating at the limits.

The stage count, the decimation factor minus one and a growth value come from configuration inputs. These are expected to be driven by a register block outside this module. A pre-shifter scales the input by the growth value so that the CIC gain (factor to the power of the stage count) cannot overflow. After scaling, the DC gain comes out close to one. Every integrator and comb stage is narrower than the one before it: its input loses its low-order bits by an arithmetic right shift. A bypass input turns the filter into a registered pass-through. A two-state controller governs operation. `ST_IDLE` is the state after reset. The transition "start accepted" moves to `ST_RUN`. `ST_RUN` holds until reset.

Top module: `cic_decimator`

## Requirements
- R1: While `rst_n` is low, and right after it is asserted at any time, `dout` is 0 and `dout_valid` is 0. Reset also clears all integrator, decimation, comb and output registers, and returns the controller to `ST_IDLE`.
- R2: In `ST_IDLE`, `din` is ignored and `dout_valid` stays 0. A high `start` at a rising edge takes the controller to `ST_RUN`, where it stays until reset. The first sample accepted is the one present at the next rising edge.
- R3: `cfg_dec_m1` (10 bits) holds the factor minus one. In filter mode, exactly one output comes from each group of `cfg_dec_m1`+1 accepted samples. A value of 0 yields one output per input, and 1023 yields one output per 1024 inputs.
- R4: The effective stage count is `cfg_stages` limited to the range 1..5: a value of 0 acts as 1, and values 6 or 7 act as 5. Stage k (1..5) is enabled when k is at most the effective count. A disabled integrator loads its input with no feedback. A disabled comb passes its input unchanged.
- R5: The input is sign-extended to 70 bits and shifted left by 53 − min(`cfg_growth`, 50). Integrator k has 70 − 2(k−1) bits, the decimation register has 60 bits, and comb k has 60 − 2k bits. Each of these registers takes the previous stage's value shifted arithmetically right by 2, except the first integrator, which takes the shifted input. Arithmetic wraps at each register's width. The last comb's value shifted right by 30 forms a 20-bit pre-round value with 3 fraction bits.
- R6: The pre-round value is rounded half away from zero to an integer. Non-negative values add 4 and then shift right by 3. Negative values add 3 and then shift right by 3.
- R7: A rounded result above 32767 becomes 32767, and one below −32768 becomes −32768. A positive pre-round value never produces a negative output.
- R8: With `cfg_bypass` high in `ST_RUN`, each `din` sampled at an edge appears on `dout` after that edge, with `dout_valid` high. The filter registers and the counter hold their values.
- R9: In filter mode, `dout_valid` is a single-cycle pulse that comes with each new output when the factor is 2 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input sample clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous start request, sampled in `ST_IDLE` |
| cfg_stages | input | 3 | Number of active stages (1..5, limited) |
| cfg_dec_m1 | input | 10 | Decimation factor minus one |
| cfg_growth | input | 6 | Growth value steering the input pre-shift |
| cfg_bypass | input | 1 | 1 = registered pass-through of `din` |
| din | input | 16 | Two's-complement input sample |
| dout | output | 16 | Rounded, saturated output sample |
| dout_valid | output | 1 | High for one cycle with each new `dout` |

## Verification
Two actions can land on the same clock edge. The first is the reload of the decimation register by the strobe. The second is the comb section reading the value that register held before that edge. This happens on every edge when the factor is 1 (`cfg_dec_m1` = 0). A dedicated case drives a pseudo-random sequence at factor 1, where every output depends on the combs consuming the previous value just as the register is overwritten. A scoreboard judges it by comparing each output, in order, against a stage-by-stage arithmetic model built from R5 and R6. Rounding ties and saturation are checked in the same way, using small-amplitude and near-full-scale sequences.

// File: rtl/cic_dec_pkg.sv
package cic_dec_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/cic_integrators.sv
module cic_integrators #(
    parameter int W0    = 70,
    parameter int DROP  = 2,
    parameter int NST   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [NST-1:0]       en,
    input  logic signed [W0-1:0] din,
    output logic signed [W0-1:0] dout
);

    logic signed [W0-1:0] tap [NST+1];

    assign tap[0] = din;

    for (genvar k = 0; k < NST; k++) begin : g_int
        localparam int WK = W0 - k * DROP;
        logic signed [WK-1:0] in_k;
        logic signed [WK-1:0] acc_q;

        if (k == 0) begin : g_first
            assign in_k = WK'(tap[0]);
        end else begin : g_rest
            assign in_k = WK'(tap[k] >>> DROP);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (adv) begin
                acc_q <= en[k] ? acc_q + in_k : in_k;
            end
        end

        assign tap[k+1] = W0'(acc_q);
    end

    assign dout = tap[NST];

endmodule

// File: rtl/cic_combs.sv
module cic_combs #(
    parameter int W0    = 70,
    parameter int DROP  = 2,
    parameter int NST   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic [NST-1:0]       en,
    input  logic signed [W0-1:0] din,
    output logic signed [W0-1:0] dout
);

    logic signed [W0-1:0] tap [NST+1];

    assign tap[0] = din;

    for (genvar k = 0; k < NST; k++) begin : g_comb
        localparam int WK = W0 - (NST + 1 + k) * DROP;
        logic signed [WK-1:0] in_k;
        logic signed [WK-1:0] dly_q;
        logic signed [WK-1:0] diff;

        assign in_k = WK'(tap[k] >>> DROP);
        assign diff = in_k - dly_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dly_q <= '0;
            end else if (stb) begin
                dly_q <= in_k;
            end
        end

        assign tap[k+1] = en[k] ? W0'(diff) : W0'(in_k);
    end

    assign dout = tap[NST];

endmodule

// File: rtl/cic_round_sat.sv
module cic_round_sat #(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 3,
    parameter int PR_W   = 20
) (
    input  logic signed [PR_W-1:0] pre,
    output logic signed [IN_W-1:0] q
);

    localparam int BW = PR_W + 1;
    localparam logic signed [BW-1:0] BIAS_UP = BW'(1 << (FRAC_W - 1));
    localparam logic signed [BW-1:0] BIAS_DN = BIAS_UP - BW'(1);
    localparam logic signed [BW-1:0] POS_LIM = {{(BW-IN_W+1){1'b0}}, {(IN_W-1){1'b1}}};
    localparam logic signed [BW-1:0] NEG_LIM = {{(BW-IN_W+1){1'b1}}, {(IN_W-1){1'b0}}};

    logic signed [BW-1:0] biased;
    logic signed [BW-1:0] shifted;

    always_comb begin
        biased  = BW'(pre) + (pre[PR_W-1] ? BIAS_DN : BIAS_UP);
        shifted = biased >>> FRAC_W;
        if (shifted > POS_LIM) begin
            q = IN_W'(POS_LIM);
        end else if (shifted < NEG_LIM) begin
            q = IN_W'(NEG_LIM);
        end else begin
            q = IN_W'(shifted);
        end
    end

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
    import cic_dec_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int FRAC_W  = 3,
    parameter int GUARD_W = 1,
    parameter int NST     = 5,
    parameter int DEC_W   = 10,
    parameter int GRW_W   = 6,
    parameter int STG_W   = 3,
    parameter int GMAX    = 50,
    parameter int DROP    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [STG_W-1:0]       cfg_stages,
    input  logic [DEC_W-1:0]       cfg_dec_m1,
    input  logic [GRW_W-1:0]       cfg_growth,
    input  logic                   cfg_bypass,
    input  logic signed [IN_W-1:0] din,
    output logic signed [IN_W-1:0] dout,
    output logic                   dout_valid
);

    localparam int PR_W = IN_W + FRAC_W + GUARD_W;
    localparam int W0   = PR_W + GMAX;
    localparam int WD   = W0 - NST * DROP;
    localparam int WL   = W0 - 2 * NST * DROP;
    localparam int SH_W = $clog2(FRAC_W + GMAX + 1);

    run_state_e               state_q, state_d;
    logic [DEC_W-1:0]         cnt_q;
    logic                     adv;
    logic                     dec_tick;
    logic                     comb_stb_q;
    logic [STG_W-1:0]         stg_eff;
    logic [NST-1:0]           stage_en;
    logic [GRW_W-1:0]         g_eff;
    logic [SH_W-1:0]          sh_amt;
    logic signed [W0-1:0]     x_ext;
    logic signed [W0-1:0]     x_pos;
    logic signed [W0-1:0]     integ_out;
    logic signed [WD-1:0]     dec_q;
    logic signed [W0-1:0]     dec_ext;
    logic signed [W0-1:0]     comb_out;
    logic signed [PR_W-1:0]   pre_rnd;
    logic signed [IN_W-1:0]   rnd;

    // configuration decode
    assign stg_eff = (cfg_stages == '0)        ? STG_W'(1)   :
                     (int'(cfg_stages) > NST)  ? STG_W'(NST) : cfg_stages;

    for (genvar k = 0; k < NST; k++) begin : g_en
        assign stage_en[k] = (int'(stg_eff) > k);
    end

    assign g_eff  = (int'(cfg_growth) > GMAX) ? GRW_W'(GMAX) : cfg_growth;
    assign sh_amt = SH_W'(FRAC_W + GMAX - int'(g_eff));
    assign x_ext  = W0'(din);
    assign x_pos  = x_ext <<< sh_amt;

    // controller: state register and next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign adv      = (state_q == ST_RUN) && !cfg_bypass;
    assign dec_tick = adv && (cnt_q == cfg_dec_m1);

    // decimation counter, held at zero until started
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= dec_tick ? '0 : cnt_q + DEC_W'(1);
        end
    end

    cic_integrators #(.W0(W0), .DROP(DROP), .NST(NST)) u_int (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .en    (stage_en),
        .din   (x_pos),
        .dout  (integ_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q      <= '0;
            comb_stb_q <= 1'b0;
        end else begin
            comb_stb_q <= dec_tick;
            if (dec_tick) begin
                dec_q <= WD'(integ_out >>> DROP);
            end
        end
    end

    assign dec_ext = W0'(dec_q);

    cic_combs #(.W0(W0), .DROP(DROP), .NST(NST)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (comb_stb_q),
        .en    (stage_en),
        .din   (dec_ext),
        .dout  (comb_out)
    );

    assign pre_rnd = PR_W'(comb_out >>> (WL - PR_W));

    cic_round_sat #(.IN_W(IN_W), .FRAC_W(FRAC_W), .PR_W(PR_W)) u_rnd (
        .pre (pre_rnd),
        .q   (rnd)
    );

    // output register, driven per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (cfg_bypass) begin
                        dout       <= din;
                        dout_valid <= 1'b1;
                    end else if (comb_stb_q) begin
                        dout       <= rnd;
                        dout_valid <= 1'b1;
                    end
                end
            endcase
        end
    end

    // assertions
    assert_run_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |=> state_q == ST_RUN);

    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |=> !dout_valid);

    assert_tick_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_tick |=> cnt_q == '0);

    assert_idle_counter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> cnt_q == '0);

    assert_bypass_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cfg_bypass) |=> dout_valid);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !cfg_bypass && cfg_dec_m1 != '0) |=> !dout_valid);

    assert_no_wrap_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_stb_q && state_q == ST_RUN && !cfg_bypass && !pre_rnd[PR_W-1])
        |=> !dout[IN_W-1]);

    assert_no_wrap_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_stb_q && state_q == ST_RUN && !cfg_bypass && pre_rnd[PR_W-1])
        |=> (dout[IN_W-1] || dout == '0));

endmodule

// File: tb/cic_decimator_tb.sv
module cic_decimator_tb_top;

    localparam int NST    = 5;
    localparam int FRAC_W = 3;
    localparam int GMAX   = 50;
    localparam int DROP   = 2;
    localparam int PR_W   = 20;
    localparam int W0     = 70;

    typedef logic signed [W0-1:0] wide_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [2:0]         cfg_stages = 3'd1;
    logic [9:0]         cfg_dec_m1 = '0;
    logic [5:0]         cfg_growth = '0;
    logic               cfg_bypass = 1'b0;
    logic signed [15:0] din = '0;
    logic signed [15:0] dout;
    logic               dout_valid;

    cic_decimator dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_stages (cfg_stages),
        .cfg_dec_m1 (cfg_dec_m1),
        .cfg_growth (cfg_growth),
        .cfg_bypass (cfg_bypass),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    int checks = 0;
    int errors = 0;
    logic signed [15:0] exp_q [$];
    string              tag_q [$];
    bit                 flushing = 1'b0;
    string              cur_tag = "R1";
    int unsigned        lcg = 32'h1234_5678;

    wide_t mi [NST];
    wide_t md [NST];
    int    mcnt, m_stg, m_r, m_g;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic wide_t wrapw(wide_t v, int w);
        wide_t t;
        t = v <<< (W0 - w);
        return t >>> (W0 - w);
    endfunction

    // R6/R7 reference: half away from zero, then clamp
    function automatic logic signed [15:0] round_ref(wide_t v);
        longint s, r;
        s = longint'(v);
        if (s < 0) r = (s + 3) >>> 3;
        else       r = (s + 4) >>> 3;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return 16'(r);
    endfunction

    // R5 stage-by-stage model for one accepted sample
    function automatic void model_step(logic signed [15:0] x);
        int    ge;
        wide_t xs, c, t, inp;
        ge = (m_g > GMAX) ? GMAX : m_g;
        xs = wide_t'(x) <<< (FRAC_W + GMAX - ge);
        if (mcnt == m_r - 1) begin
            c = wrapw(mi[NST-1] >>> DROP, W0 - NST * DROP);
            for (int k = 0; k < NST; k++) begin
                int w;
                w = W0 - (NST + 1 + k) * DROP;
                t = wrapw(c >>> DROP, w);
                if (k < m_stg) c = wrapw(t - md[k], w);
                else           c = t;
                md[k] = t;
            end
            exp_q.push_back(round_ref(c >>> (W0 - 2 * NST * DROP - PR_W)));
            tag_q.push_back(cur_tag);
            mcnt = 0;
        end else begin
            mcnt++;
        end
        for (int k = NST - 1; k >= 0; k--) begin
            int w;
            w = W0 - k * DROP;
            if (k == 0) inp = xs;
            else        inp = mi[k-1] >>> DROP;
            if (k < m_stg) mi[k] = wrapw(mi[k] + inp, w);
            else           mi[k] = wrapw(inp, w);
        end
    endfunction

    function automatic logic signed [15:0] pat(int kind, int i, int a);
        int r;
        case (kind)
            0: return 16'(a);
            1: return 16'(a * i - 40);
            2: begin lcg = lcg * 1103515245 + 12345; return lcg[30:15]; end
            3: return (i % 2 == 1) ? 16'(-a) : 16'(a);
            default: begin
                lcg = lcg * 1103515245 + 12345;
                r = int'(lcg[20:16]) % 13;
                return 16'(r - 6);
            end
        endcase
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && dout_valid) begin
            if (exp_q.size() > 0) begin
                logic signed [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dout === e, t, "output sample", int'(dout), int'(e));
            end else if (!flushing) begin
                check(1'b0, cur_tag, "unexpected output", int'(dout), 0);
            end
        end
    end

    task automatic run_case(string tag, int stg, int dm1, int g, bit byp,
                            int kind, int amp, int n);
        @(posedge clk); #1;
        rst_n = 1'b0;
        flushing = 1'b0;
        #1;
        check(dout === 16'sd0 && dout_valid === 1'b0, "R1", "reset clears output",
              int'(dout), 0);
        exp_q.delete();
        tag_q.delete();
        cur_tag    = tag;
        cfg_stages = 3'(stg);
        cfg_dec_m1 = 10'(dm1);
        cfg_growth = 6'(g);
        cfg_bypass = byp;
        for (int k = 0; k < NST; k++) begin mi[k] = '0; md[k] = '0; end
        mcnt  = 0;
        m_stg = (stg == 0) ? 1 : ((stg > NST) ? NST : stg);
        m_r   = dm1 + 1;
        m_g   = g;
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R2: data before start is ignored
        for (int i = 0; i < 4; i++) begin
            din = 16'sd12345 - 16'(i * 999);
            @(posedge clk); #1;
        end
        check(dout === 16'sd0, "R2", "no output before start", int'(dout), 0);
        start = 1'b1;
        din   = 16'sd7777;
        @(posedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            din = pat(kind, i, amp);
            if (byp) begin
                exp_q.push_back(din);
                tag_q.push_back(tag);
            end else begin
                model_step(din);
            end
            @(posedge clk); #1;
        end
        flushing = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R3", "all expected outputs seen", exp_q.size(), 0);
    endtask

    initial begin
        #2;
        check(dout === 16'sd0 && dout_valid === 1'b0, "R1", "initial reset state",
              int'(dout), 0);
        repeat (2) @(posedge clk);
        run_case("R6", 1, 4,    3,  1'b0, 1, 7,     60);
        run_case("R6", 1, 2,    2,  1'b0, 4, 0,     90);
        run_case("R5", 3, 7,    9,  1'b0, 2, 0,     300);
        run_case("R5", 5, 15,   20, 1'b0, 0, 1000,  400);
        run_case("R3", 2, 0,    0,  1'b0, 2, 0,     100);
        run_case("R7", 1, 1,    0,  1'b0, 0, 30000, 20);
        run_case("R7", 1, 1,    0,  1'b0, 0, -30000, 20);
        run_case("R7", 2, 3,    2,  1'b0, 3, 32000, 40);
        run_case("R4", 0, 3,    2,  1'b0, 2, 0,     80);
        run_case("R4", 7, 3,    10, 1'b0, 2, 0,     120);
        run_case("R4", 4, 5,    11, 1'b0, 2, 0,     150);
        run_case("R3", 2, 1023, 20, 1'b0, 0, -5000, 3082);
        run_case("R5", 5, 1023, 63, 1'b0, 0, 20000, 3082);
        run_case("R8", 3, 9,    5,  1'b1, 2, 0,     30);
        @(posedge clk); #1;
        rst_n = 1'b0;
        #1;
        check(dout === 16'sd0 && dout_valid === 1'b0, "R1", "final reset clears",
              int'(dout), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule